// File: doc/BRIEF.md
# CRC Accumulate Execution Unit

This functional unit executes a CRC accumulate instruction inside a processor pipeline. The issue stage presents the 32-bit instruction word together with two operands already read from the register file. One is the running 32-bit CRC, taken from the register named by the rt field. The other is the message word, taken from the register named by the rs field. The unit decodes the word and checks it against the configuration enable and the 64-bit mode flag. It then folds 1, 2, 4 or 8 message bytes into the CRC, lowest byte first, at one byte per clock. The polynomial is either the IEEE CRC-32 polynomial or the Castagnoli CRC-32C polynomial.

The result is sign-extended to the register width. It is presented for write-back to the rt register together with a result-valid strobe. When rt is register 0, the strobe still fires but the write enable stays low. A word that matches the instruction pattern but may not execute produces a one-cycle reserved-instruction flag and no result. Words that do not match the pattern are left alone. The CRC is not inverted on entry or exit, so software applies any initial value and any final inversion itself, and it chains calls by passing each result back in as the next CRC.

Control is a three-state machine. IDLE waits for an accepted issue. The transition IDLE to RUN loads the operands on a valid, enabled instruction. RUN to RUN folds one byte while bytes remain. RUN to DONE follows the last byte. DONE to IDLE is unconditional after the single result cycle. A reserved or unrecognised word leaves the machine in IDLE.

Top module: `crcx_unit`

## Requirements
- R1: An issued word is recognised only when bits 31:26 are 011111, bits 15:11 are 00000 and bits 5:0 are 001111; any other word raises neither the reserved flag nor a result.
- R2: The type field in bits 10:8 selects the polynomial: 0 gives reflected 0xEDB88320 (CRC-32) and 1 gives reflected 0x82F63B78 (CRC-32C), each applied LSB-first.
- R3: A recognised word whose type field is 2 or more raises the reserved flag.
- R4: A recognised word raises the reserved flag whenever the CRC-enable configuration input is low.
- R5: A recognised word with size field 3 raises the reserved flag when the 64-bit mode input is low.
- R6: The size field in bits 7:6 gives 1 << sz message bytes, taken from the low end of the message operand lowest byte first; the message bits above them have no effect.
- R7: The rs index output equals bits 25:21 and the rt index output equals bits 20:16 of the issued word; the result is written to the rt register.
- R8: The write-back data is the 32-bit CRC sign-extended to the register width.
- R9: When the rt field is 0 the result strobe fires but the write enable stays low.
- R10: The result strobe is high for exactly one cycle, 1 + (1 << sz) cycles after the accepting clock edge, and busy is high from acceptance until that cycle ends.
- R11: The reserved flag is a one-cycle pulse in the cycle after issue, with no result strobe, and the unit stays idle.
- R12: An issue presented while busy is ignored.
- R13: After reset the unit is idle, with busy, reserved flag, result strobe and write enable low.
- R14: No inversion is applied inside the operation, so chaining gives standard results (CRC-32 of "123456789" with initial value all ones and a final inversion is 0xCBF43926; CRC-32C gives 0xE3069283).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction word is presented this cycle |
| issue_instr | input | 32 | Instruction word |
| cfg_crc_en | input | 1 | Configuration enable for the CRC instruction |
| mode64 | input | 1 | 64-bit operation enabled |
| msg_val | input | XLEN | Message operand read from register rs |
| crc_src | input | 32 | Running CRC read from register rt (low word) |
| rs_idx | output | 5 | Register index for the message read |
| rt_idx | output | 5 | Register index for the CRC read |
| busy | output | 1 | An operation is in flight; new issues are not accepted |
| ri_flag | output | 1 | Reserved-instruction pulse |
| wb_valid | output | 1 | Result strobe |
| wb_we | output | 1 | Register write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | XLEN | Sign-extended CRC result |

## Verification
Operations cover every size under both polynomials. The message operands carry non-zero bytes above the active width, so a wrong byte count or a missing mask shows up as a mismatch against a bitwise reference model. Starting CRC values include zero, all ones and single high or low bits, and the upper half of the result is checked, which separates sign extension from zero extension. Reserved words are tried one cause at a time: an illegal type field, a cleared enable, and size 3 with 64-bit mode off. Each is shown to pulse the flag without producing a result. The check-value chain over "123456789" ties the byte order and the absence of inversion to the published CRC-32 and CRC-32C results.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    localparam logic [5:0]  OPC_MAJOR  = 6'b011111;
    localparam logic [5:0]  OPC_FUNC   = 6'b001111;
    localparam logic [4:0]  OPC_ZERO   = 5'b00000;
    localparam logic [31:0] POLY_IEEE  = 32'hEDB88320;
    localparam logic [31:0] POLY_CAST  = 32'h82F63B78;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } crcx_state_e;

    typedef struct packed {
        logic       hit;
        logic       reserved;
        logic       castagnoli;
        logic [1:0] size_log2;
        logic [4:0] src_msg;
        logic [4:0] src_dst;
    } crcx_dec_t;

endpackage

// File: rtl/crcx_decode.sv
module crcx_decode
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0] instr,
    input  logic        cfg_crc_en,
    input  logic        mode64,
    output crcx_dec_t   dec
);

    logic [2:0] type_fld;
    logic [1:0] size_fld;
    logic       wide_ok;

    assign type_fld = instr[10:8];
    assign size_fld = instr[7:6];

    // Eight-byte operands need both a wide datapath and 64-bit mode.
    generate
        if (XLEN >= 64) begin : g_wide
            assign wide_ok = mode64;
        end else begin : g_narrow
            assign wide_ok = 1'b0 & mode64;
        end
    endgenerate

    always_comb begin
        dec            = '0;
        dec.hit        = (instr[31:26] == OPC_MAJOR) &&
                         (instr[15:11] == OPC_ZERO)  &&
                         (instr[5:0]   == OPC_FUNC);
        dec.reserved   = !cfg_crc_en
                       || (type_fld >= 3'd2)
                       || ((size_fld == 2'd3) && !wide_ok);
        dec.castagnoli = type_fld[0];
        dec.size_log2  = size_fld;
        dec.src_msg    = instr[25:21];
        dec.src_dst    = instr[20:16];
    end

endmodule

// File: rtl/crcx_byte_step.sv
module crcx_byte_step #(
    parameter int CRC_W     = 32,
    parameter int STEP_BITS = 8
) (
    input  logic [CRC_W-1:0]     crc_in,
    input  logic [STEP_BITS-1:0] data_in,
    input  logic [CRC_W-1:0]     poly,
    output logic [CRC_W-1:0]     crc_out
);

    localparam int PAD_W = CRC_W - STEP_BITS;

    logic [CRC_W-1:0] stage [0:STEP_BITS];

    assign stage[0] = crc_in ^ {{PAD_W{1'b0}}, data_in};

    // One reflected shift per message bit, unrolled.
    generate
        for (genvar g = 0; g < STEP_BITS; g++) begin : g_bit
            assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ poly)
                                            :  (stage[g] >> 1);
        end
    endgenerate

    assign crc_out = stage[STEP_BITS];

endmodule

// File: rtl/crcx_engine.sv
module crcx_engine
    import crcx_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int CRC_W     = 32,
    parameter int IDX_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   castagnoli,
    input  logic [1:0]             size_log2,
    input  logic [CRC_W-1:0]       crc_init,
    input  logic [8*MAX_BYTES-1:0] msg,
    input  logic [IDX_W-1:0]       dst_in,
    output logic                   busy,
    output logic                   done,
    output logic [CRC_W-1:0]       crc_out,
    output logic [IDX_W-1:0]       dst_out
);

    localparam int MSG_W = 8 * MAX_BYTES;
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    crcx_state_e        state, state_nx;
    logic [CRC_W-1:0]   crc_q;
    logic [CRC_W-1:0]   poly_q;
    logic [MSG_W-1:0]   msg_q;
    logic [CNT_W-1:0]   left_q;
    logic [IDX_W-1:0]   dst_q;
    logic [CNT_W-1:0]   nbytes;
    logic [CRC_W-1:0]   step_crc;

    assign nbytes = CNT_W'(1) << size_log2;

    function automatic logic [MSG_W-1:0] keep_bytes(input logic [CNT_W-1:0] n);
        logic [MSG_W-1:0] m;
        m = '0;
        for (int b = 0; b < MAX_BYTES; b++) begin
            if (b < int'(n)) m[8*b +: 8] = 8'hFF;
        end
        return m;
    endfunction

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)          state_nx = ST_RUN;
            ST_RUN:  if (left_q == CNT_W'(1)) state_nx = ST_DONE;
            ST_DONE:                     state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= '0;
            poly_q <= '0;
            msg_q  <= '0;
            left_q <= '0;
            dst_q  <= '0;
        end else if (state == ST_IDLE && start) begin
            crc_q  <= crc_init;
            poly_q <= castagnoli ? POLY_CAST : POLY_IEEE;
            msg_q  <= msg & keep_bytes(nbytes);
            left_q <= nbytes;
            dst_q  <= dst_in;
        end else if (state == ST_RUN) begin
            crc_q  <= step_crc;
            msg_q  <= msg_q >> 8;
            left_q <= left_q - CNT_W'(1);
        end
    end

    crcx_byte_step #(
        .CRC_W     (CRC_W),
        .STEP_BITS (8)
    ) u_step (
        .crc_in  (crc_q),
        .data_in (msg_q[7:0]),
        .poly    (poly_q),
        .crc_out (step_crc)
    );

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: begin busy = 1'b0; done = 1'b0; end
            ST_RUN:  begin busy = 1'b1; done = 1'b0; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: begin busy = 1'b0; done = 1'b0; end
        endcase
    end

    assign crc_out = crc_q;
    assign dst_out = dst_q;

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (left_q != '0 && int'(left_q) <= MAX_BYTES));

    assert_last_byte_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && left_q == CNT_W'(1)) |=> done);

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));

endmodule

// File: rtl/crcx_unit.sv
module crcx_unit
    import crcx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue_valid,
    input  logic [31:0]     issue_instr,
    input  logic            cfg_crc_en,
    input  logic            mode64,
    input  logic [XLEN-1:0] msg_val,
    input  logic [31:0]     crc_src,
    output logic [4:0]      rs_idx,
    output logic [4:0]      rt_idx,
    output logic            busy,
    output logic            ri_flag,
    output logic            wb_valid,
    output logic            wb_we,
    output logic [4:0]      wb_idx,
    output logic [XLEN-1:0] wb_data
);

    localparam int CRC_W     = 32;
    localparam int MAX_BYTES = XLEN / 8;
    localparam int EXT_W     = XLEN - CRC_W;

    crcx_dec_t        dec;
    logic             accept;
    logic             start;
    logic             ri_q;
    logic             eng_done;
    logic [CRC_W-1:0] eng_crc;
    logic [4:0]       eng_dst;

    crcx_decode #(.XLEN(XLEN)) u_dec (
        .instr      (issue_instr),
        .cfg_crc_en (cfg_crc_en),
        .mode64     (mode64),
        .dec        (dec)
    );

    assign rs_idx = dec.src_msg;
    assign rt_idx = dec.src_dst;
    assign accept = issue_valid && !busy && dec.hit;
    assign start  = accept && !dec.reserved;

    always_ff @(posedge clk) begin
        if (!rst_n) ri_q <= 1'b0;
        else        ri_q <= accept && dec.reserved;
    end

    crcx_engine #(
        .MAX_BYTES (MAX_BYTES),
        .CRC_W     (CRC_W),
        .IDX_W     (5)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .castagnoli (dec.castagnoli),
        .size_log2  (dec.size_log2),
        .crc_init   (crc_src),
        .msg        (msg_val),
        .dst_in     (dec.src_dst),
        .busy       (busy),
        .done       (eng_done),
        .crc_out    (eng_crc),
        .dst_out    (eng_dst)
    );

    assign ri_flag  = ri_q;
    assign wb_valid = eng_done;
    assign wb_idx   = eng_dst;
    assign wb_we    = eng_done && (eng_dst != 5'd0);

    generate
        if (EXT_W > 0) begin : g_sext
            assign wb_data = {{EXT_W{eng_crc[CRC_W-1]}}, eng_crc};

            assert_sign_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
                wb_valid |-> (wb_data[XLEN-1:CRC_W] == {EXT_W{wb_data[CRC_W-1]}}));
        end else begin : g_flat
            assign wb_data = eng_crc;
        end
    endgenerate

    assert_ri_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ri_flag |-> (!wb_valid && !busy));

    assert_ri_after_issue_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ri_flag |-> $past(issue_valid));

    assert_ri_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ri_flag |=> !ri_flag);

    assert_we_dest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_we |-> (wb_valid && wb_idx != 5'd0));

endmodule

// File: tb/sim_crcx_unit.sv
`timescale 1ns/1ps
module sim_crcx_unit;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            issue_valid;
    logic [31:0]     issue_instr;
    logic            cfg_crc_en;
    logic            mode64;
    logic [XLEN-1:0] msg_val;
    logic [31:0]     crc_src;
    logic [4:0]      rs_idx, rt_idx, wb_idx;
    logic            busy, ri_flag, wb_valid, wb_we;
    logic [XLEN-1:0] wb_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    crcx_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_instr(issue_instr),
        .cfg_crc_en(cfg_crc_en), .mode64(mode64), .msg_val(msg_val), .crc_src(crc_src),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .busy(busy), .ri_flag(ri_flag),
        .wb_valid(wb_valid), .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    // {type[3], size[2], rt[5], enable, mode64, expect_ri, msg[64], crc[32]}
    localparam logic [108:0] VEC [0:13] = '{
        {3'd0, 2'd0, 5'd3,  1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF31, 32'hFFFF_FFFF},
        {3'd0, 2'd1, 5'd4,  1'b1, 1'b1, 1'b0, 64'h1234_5678_9ABC_3231, 32'h0000_0000},
        {3'd0, 2'd2, 5'd5,  1'b1, 1'b1, 1'b0, 64'hDEAD_BEEF_3433_3231, 32'h1234_5678},
        {3'd0, 2'd3, 5'd6,  1'b1, 1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 32'hFFFF_FFFF},
        {3'd1, 2'd0, 5'd7,  1'b1, 1'b1, 1'b0, 64'h7777_0000_0000_00A5, 32'hFFFF_FFFF},
        {3'd1, 2'd1, 5'd8,  1'b1, 1'b1, 1'b0, 64'hAAAA_5555_0000_F00F, 32'h8000_0000},
        {3'd1, 2'd2, 5'd9,  1'b1, 1'b1, 1'b0, 64'hCAFE_F00D_1357_9BDF, 32'h7FFF_FFFF},
        {3'd1, 2'd3, 5'd31, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_0001, 32'h0000_0000},
        {3'd0, 2'd3, 5'd10, 1'b1, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 32'h0000_0001},
        {3'd2, 2'd0, 5'd11, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0055, 32'h0000_0002},
        {3'd7, 2'd1, 5'd12, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_5555, 32'h0000_0003},
        {3'd1, 2'd2, 5'd13, 1'b0, 1'b1, 1'b1, 64'h0000_0000_5555_5555, 32'h0000_0004},
        {3'd0, 2'd2, 5'd0,  1'b1, 1'b1, 1'b0, 64'h0000_0000_6162_6364, 32'hFFFF_FFFF},
        {3'd1, 2'd3, 5'd1,  1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000}
    };

    function automatic logic [31:0] ref_crc(input logic [31:0] crc, input logic [63:0] msg,
                                            input int n, input logic cast);
        logic [31:0] p;
        logic [31:0] r;
        p = cast ? 32'h82F63B78 : 32'hEDB88320;
        r = crc;
        for (int b = 0; b < n; b++) begin
            r[7:0] = r[7:0] ^ msg[8*b +: 8];
            for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [2:0] c, input logic [1:0] sz);
        return {6'b011111, rs, rt, 5'b00000, c, sz, 6'b001111};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        issue_valid = 1'b0;
        issue_instr = 32'h0;
        msg_val     = '0;
        crc_src     = 32'h0;
    endtask

    task automatic run_op(input logic [2:0] c, input logic [1:0] sz, input logic [4:0] rs,
                          input logic [4:0] rt, input logic en, input logic m64,
                          input logic exp_ri, input logic [63:0] msg, input logic [31:0] crc,
                          output logic [31:0] res);
        int n;
        int cnt;
        logic [31:0] e;
        n   = 1 << sz;
        res = 32'h0;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_instr = mk(rs, rt, c, sz);
        cfg_crc_en  = en;
        mode64      = m64;
        msg_val     = msg;
        crc_src     = crc;
        #1;
        chk(rs_idx == rs, "R7 rs index", 64'(rs_idx), 64'(rs));
        chk(rt_idx == rt, "R7 rt index", 64'(rt_idx), 64'(rt));
        @(negedge clk);
        idle_inputs();
        if (exp_ri) begin
            chk(ri_flag && !wb_valid && !busy, "R3/R4/R5/R11 reserved pulse",
                64'({ri_flag, wb_valid, busy}), 64'(3'b100));
            @(negedge clk);
            chk(!ri_flag && !wb_valid && !busy, "R11 pulse ends",
                64'({ri_flag, wb_valid, busy}), 64'(3'b000));
        end else begin
            cnt = 1;
            while (!wb_valid && cnt < 20) begin
                chk(busy, "R10 busy while running", 64'(busy), 64'(1));
                @(negedge clk);
                cnt++;
            end
            chk(cnt == n + 1, "R10 latency", 64'(cnt), 64'(n + 1));
            e = ref_crc(crc, msg, n, c[0]);
            chk(wb_data == {{32{e[31]}}, e}, "R2/R6/R8 result", wb_data, {{32{e[31]}}, e});
            chk(wb_idx == rt, "R7 dest index", 64'(wb_idx), 64'(rt));
            chk(wb_we == (rt != 5'd0), "R9 write enable", 64'(wb_we), 64'(rt != 5'd0));
            chk(!ri_flag, "R11 no reserved on legal op", 64'(ri_flag), 64'(0));
            res = wb_data[31:0];
            @(negedge clk);
            chk(!wb_valid && !busy, "R10 single strobe", 64'({wb_valid, busy}), 64'(0));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r1, r2;
        idle_inputs();
        cfg_crc_en = 1'b1;
        mode64     = 1'b1;
        rst_n      = 1'b0;
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !ri_flag && !wb_valid && !wb_we, "R13 reset idle",
            64'({busy, ri_flag, wb_valid, wb_we}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wb_valid, "R13 idle after reset", 64'({busy, wb_valid}), 64'(0));

        for (int i = 0; i < 14; i++) begin
            logic [108:0] v;
            v = VEC[i];
            run_op(v[108:106], v[105:104], 5'(i + 17), v[103:99], v[98], v[97], v[96],
                   v[95:32], v[31:0], r1);
        end

        // R14: check values via chaining, no internal inversion
        run_op(3'd0, 2'd3, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h3837363534333231, 32'hFFFF_FFFF, r1);
        run_op(3'd0, 2'd0, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h39, r1, r2);
        chk((r2 ^ 32'hFFFF_FFFF) == 32'hCBF43926, "R14 CRC-32 check value",
            64'(r2 ^ 32'hFFFF_FFFF), 64'(32'hCBF43926));
        run_op(3'd1, 2'd2, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h34333231, 32'hFFFF_FFFF, r1);
        run_op(3'd1, 2'd2, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h38373635, r1, r2);
        run_op(3'd1, 2'd0, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h39, r2, r1);
        chk((r1 ^ 32'hFFFF_FFFF) == 32'hE3069283, "R14 CRC-32C check value",
            64'(r1 ^ 32'hFFFF_FFFF), 64'(32'hE3069283));

        // R6: upper message bits have no effect
        run_op(3'd0, 2'd1, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_BEEF, 32'h55AA_55AA, r1);
        run_op(3'd0, 2'd1, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 64'h9876_5432_1000_BEEF, 32'h55AA_55AA, r2);
        chk(r1 == r2, "R6 upper bits ignored", 64'(r2), 64'(r1));

        // R1: near-miss words are not recognised
        for (int w = 0; w < 3; w++) begin
            logic [31:0] word;
            word = mk(5'd3, 5'd4, 3'd0, 2'd0);
            if (w == 0) word[15:11] = 5'b00100;
            if (w == 1) word[5:0]   = 6'b001110;
            if (w == 2) word[31:26] = 6'b011110;
            @(negedge clk);
            issue_valid = 1'b1;
            issue_instr = word;
            msg_val     = 64'h12;
            @(negedge clk);
            idle_inputs();
            begin
                int seen;
                seen = 0;
                for (int k = 0; k < 12; k++) begin
                    if (ri_flag || wb_valid || busy) seen++;
                    @(negedge clk);
                end
                chk(seen == 0, "R1 unrecognised word ignored", 64'(seen), 64'(0));
            end
        end

        // R12: issue while busy is ignored
        @(negedge clk);
        issue_valid = 1'b1;
        issue_instr = mk(5'd2, 5'd14, 3'd0, 2'd3);
        msg_val     = 64'h0102_0304_0506_0708;
        crc_src     = 32'hFFFF_FFFF;
        @(negedge clk);
        chk(busy, "R10 busy after accept", 64'(busy), 64'(1));
        issue_instr = mk(5'd2, 5'd15, 3'd1, 2'd0);
        msg_val     = 64'hAB;
        crc_src     = 32'h0;
        @(negedge clk);
        idle_inputs();
        begin
            int strobes;
            logic [31:0] ea;
            strobes = 0;
            ea = ref_crc(32'hFFFF_FFFF, 64'h0102_0304_0506_0708, 8, 1'b0);
            for (int k = 0; k < 20; k++) begin
                if (wb_valid) begin
                    strobes++;
                    chk(wb_idx == 5'd14 && wb_data[31:0] == ea, "R12 first op result",
                        {27'(0), wb_idx, wb_data[31:0]}, {27'(0), 5'd14, ea});
                end
                chk(!ri_flag, "R12 no reserved from ignored issue", 64'(ri_flag), 64'(0));
                @(negedge clk);
            end
            chk(strobes == 1, "R12 only one result", 64'(strobes), 64'(1));
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule